// File: doc/BRIEF.md
# Pixel Colour Matrix Converter

This block sits in a display pipe and converts one three-channel pixel on each clock. For each output channel it subtracts a per-channel offset from the inputs, forms a weighted sum through a signed 3x3 gain matrix, adds a per-channel output offset, then rounds and clamps the result to the pixel width. The usual use is to squeeze full-range RGB (0..255) into limited-range RGB (16..235). With unity gains on the diagonal the block passes pixels through unchanged, so it can stay in the path all the time.

Software sets the block up through 32-bit registers on a write-strobe bus. Each register write lands in a shadow copy. The whole shadow set moves into the working copy on a frame-start strobe, so one frame never uses a mix of old and new settings. A per-pixel enable sends a pixel around the matrix unchanged, with the same latency. Gains use a compact 16-bit floating code, and two gains share one register word.

Top module: `csc_matrix`

## Requirements
- R1: After reset `out_valid` is 0 and both the shadow and working settings hold the identity setup: diagonal gains 0x7800, off-diagonal gains 0, all offsets 0, both mode flags clear. Pixels then pass through unchanged and `out_pre_gamma` is 0.
- R2: A pixel presented with `in_valid` high appears with `out_valid` high exactly 3 clock edges later. Idle cycles in the input produce idle cycles in the output.
- R3: Channel j of a pixel occupies bits [8j+7:8j] (DATA_W=8). Output channel k is clamp(round(sum over j of g[k][j]*(p[j] - pre[j]*(2^N-1)/8192) + post[k]*(2^N-1)/8192)). The input offset is applied first, then the matrix, then the output offset.
- R4: A gain code has its sign in bit 15, an exponent e in bits 14:12 and a mantissa m in bits 11:3. Bits 2:0 are ignored. The magnitude is m/512 when e=0 and m*2^(e-6)/512 otherwise, so 0x7800 is exactly 1.0.
- R5: Byte offset 0x10+8r holds g[r][0] in bits 31:16 and g[r][1] in bits 15:0. Offset 0x14+8r holds g[r][2] in bits 31:16, for rows r=0..2. Input offsets sit at 0x30/0x34/0x38 and output offsets at 0x40/0x44/0x48, each in bits 12:0. The mode word is at 0x28: bit 1 is the before-gamma flag and bit 2 is the fixed black offset. Writes to any other offset change nothing.
- R6: Diagonal gain code 0x0DB8 with output offsets of 514 maps input 0 to 16 and input 255 to 235 on every channel.
- R7: While the working black-offset flag is set, every channel adds the fixed output offset 514 and the programmed output-offset registers have no effect.
- R8: Rounding is to nearest, with ties going up. Results below 0 give 0, and results above 2^N-1 give 2^N-1.
- R9: Register writes change only the shadow copy. The working copy loads the shadow on `frame_start`. A write in the same cycle as `frame_start` is not in that load; it takes effect at the next `frame_start`.
- R10: A valid pixel with `in_csc_en` low comes out equal to its input, with the latency of R2, whatever the settings.
- R11: `out_pre_gamma` shows the before-gamma flag of the working copy, so it changes only after a `frame_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| frame_start | input | 1 | Loads the shadow settings into the working copy |
| in_valid | input | 1 | Input pixel valid |
| in_csc_en | input | 1 | 1: convert the pixel, 0: pass it through unchanged |
| in_pix | input | 3*DATA_W | Input pixel, channel 0 in the low bits |
| out_valid | output | 1 | Output pixel valid |
| out_pix | output | 3*DATA_W | Output pixel |
| out_pre_gamma | output | 1 | Working before-gamma flag |

## Verification
The case that needs care is a register write that lands in the same cycle as `frame_start`. The bench writes an input offset together with the strobe. It then checks that the pixels of the next frame still use the old value, and that the pixels after the following strobe use the new one. Converted and bypassed pixels are also sent back to back, so the two data paths share the same pipeline cycles. Every output is compared each clock against an arithmetic model of the requirements.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int CFG_AW    = 8;
    localparam int CODE_W    = 16;
    localparam int OFS_W     = 13;
    localparam int COEF_FRAC = 14;   // fixed-point fraction bits of a decoded gain

    localparam logic [CFG_AW-1:0] COEF_BASE = 8'h10;
    localparam logic [CFG_AW-1:0] MODE_ADDR = 8'h28;
    localparam logic [CFG_AW-1:0] PRE_BASE  = 8'h30;
    localparam logic [CFG_AW-1:0] POST_BASE = 8'h40;

    localparam logic [CODE_W-1:0] UNITY_CODE  = 16'h7800;
    localparam logic [OFS_W-1:0]  BLACK_CODE  = 13'd514;  // 16/255 of full scale

    typedef struct packed {
        logic [2:0][2:0][CODE_W-1:0] coef;  // [out channel][in channel]
        logic [2:0][OFS_W-1:0]       pre;
        logic [2:0][OFS_W-1:0]       post;
        logic                        before_gamma;
        logic                        black_ofs;
    } cfg_t;

    function automatic cfg_t cfg_identity();
        cfg_t c;
        c = '0;
        for (int i = 0; i < 3; i++) c.coef[i][i] = UNITY_CODE;
        return c;
    endfunction

endpackage

// File: rtl/csc_coef_dec.sv
module csc_coef_dec
    import csc_pkg::*;
(
    input  logic [CODE_W-1:0]        code,
    output logic signed [CODE_W-1:0] gain     // COEF_FRAC fraction bits
);
    logic [2:0]  ex;
    logic [8:0]  man;
    logic [2:0]  sh;
    logic [14:0] mag;

    always_comb begin
        ex   = code[14:12];
        man  = code[11:3];
        sh   = (ex == 3'd0) ? 3'd5 : (ex - 3'd1);
        mag  = 15'(man) << sh;
        gain = code[15] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
    end
endmodule

// File: rtl/csc_regs.sv
module csc_regs
    import csc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic              frame_start,
    output cfg_t              active
);
    typedef struct packed {
        cfg_t shadow;
        cfg_t active;
    } regs_t;

    localparam cfg_t  IDENT  = cfg_identity();
    localparam regs_t RST_ST = '{shadow: IDENT, active: IDENT};

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (frame_start) regs_d.active = regs_q.shadow;
        if (we) begin
            for (int r = 0; r < 3; r++) begin
                if (addr == COEF_BASE + 8'(8 * r)) begin
                    regs_d.shadow.coef[r][0] = wdata[31:16];
                    regs_d.shadow.coef[r][1] = wdata[15:0];
                end
                if (addr == COEF_BASE + 8'(8 * r + 4))
                    regs_d.shadow.coef[r][2] = wdata[31:16];
                if (addr == PRE_BASE + 8'(4 * r))
                    regs_d.shadow.pre[r] = wdata[OFS_W-1:0];
                if (addr == POST_BASE + 8'(4 * r))
                    regs_d.shadow.post[r] = wdata[OFS_W-1:0];
            end
            if (addr == MODE_ADDR) begin
                regs_d.shadow.before_gamma = wdata[1];
                regs_d.shadow.black_ofs    = wdata[2];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= RST_ST;
        else        regs_q <= regs_d;
    end

    assign active = regs_q.active;

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(regs_q.active));

    // R9
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (regs_q.active == $past(regs_q.shadow)));
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
    import csc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  cfg_t                  cfg,
    input  logic                  in_valid,
    input  logic                  in_csc_en,
    input  logic [3*DATA_W-1:0]   in_pix,
    output logic                  out_valid,
    output logic [3*DATA_W-1:0]   out_pix
);
    localparam int PIX_W   = 3 * DATA_W;
    localparam int MAXV    = (1 << DATA_W) - 1;
    localparam int OFS_MUL = 2 * MAXV;            // offset code -> 2^-COEF_FRAC LSB units
    localparam int X_W     = DATA_W + COEF_FRAC + 2;
    localparam int ACC_W   = X_W + CODE_W + 2;
    localparam int RND_SH  = 2 * COEF_FRAC;
    localparam logic signed [ACC_W-1:0] HALF   = ACC_W'(64'd1 << (RND_SH - 1));
    localparam logic signed [ACC_W-1:0] MAXV_A = ACC_W'(MAXV);

    typedef struct packed {
        logic                  valid;
        logic                  bypass;
        logic [PIX_W-1:0]      raw;
        logic [2:0][X_W-1:0]   x;
    } s1_t;

    typedef struct packed {
        logic                  valid;
        logic                  bypass;
        logic [PIX_W-1:0]      raw;
        logic [2:0][ACC_W-1:0] acc;
    } s2_t;

    typedef struct packed {
        logic             valid;
        logic [PIX_W-1:0] pix;
    } s3_t;

    typedef struct packed {
        s1_t s1;
        s2_t s2;
        s3_t s3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;
    logic signed [CODE_W-1:0] gain [3][3];

    for (genvar k = 0; k < 3; k++) begin : g_row
        for (genvar j = 0; j < 3; j++) begin : g_col
            csc_coef_dec u_dec (.code(cfg.coef[k][j]), .gain(gain[k][j]));
        end
    end

    always_comb begin
        logic [X_W-1:0]           pre_sc;
        logic [OFS_W-1:0]         post_k;
        logic signed [ACC_W-1:0]  sum;
        logic signed [ACC_W-1:0]  xe;
        logic signed [ACC_W-1:0]  ge;
        logic signed [ACC_W-1:0]  rnd;

        pipe_d = pipe_q;

        // stage 1: input offset
        pipe_d.s1.valid  = in_valid;
        pipe_d.s1.bypass = !in_csc_en;
        pipe_d.s1.raw    = in_pix;
        for (int j = 0; j < 3; j++) begin
            pre_sc = X_W'(cfg.pre[j]) * X_W'(OFS_MUL);
            pipe_d.s1.x[j] = {2'b00, in_pix[j*DATA_W +: DATA_W], {COEF_FRAC{1'b0}}} - pre_sc;
        end

        // stage 2: matrix and output offset
        pipe_d.s2.valid  = pipe_q.s1.valid;
        pipe_d.s2.bypass = pipe_q.s1.bypass;
        pipe_d.s2.raw    = pipe_q.s1.raw;
        for (int k = 0; k < 3; k++) begin
            post_k = cfg.black_ofs ? BLACK_CODE : cfg.post[k];
            sum = (ACC_W'(post_k) * ACC_W'(OFS_MUL)) <<< COEF_FRAC;
            for (int j = 0; j < 3; j++) begin
                xe  = ACC_W'($signed(pipe_q.s1.x[j]));
                ge  = ACC_W'(gain[k][j]);
                sum = sum + xe * ge;
            end
            pipe_d.s2.acc[k] = sum;
        end

        // stage 3: round and clamp
        pipe_d.s3.valid = pipe_q.s2.valid;
        for (int k = 0; k < 3; k++) begin
            rnd = ($signed(pipe_q.s2.acc[k]) + HALF) >>> RND_SH;
            if (pipe_q.s2.bypass)
                pipe_d.s3.pix[k*DATA_W +: DATA_W] = pipe_q.s2.raw[k*DATA_W +: DATA_W];
            else if (rnd < 0)
                pipe_d.s3.pix[k*DATA_W +: DATA_W] = '0;
            else if (rnd > MAXV_A)
                pipe_d.s3.pix[k*DATA_W +: DATA_W] = DATA_W'(MAXV);
            else
                pipe_d.s3.pix[k*DATA_W +: DATA_W] = rnd[DATA_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.s3.valid;
    assign out_pix   = pipe_q.s3.pix;

    // R2
    lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);

    // R2
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##2 !out_valid);

    // R10
    byp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_csc_en) |=> ##2 (out_pix == $past(in_pix, 3)));
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [31:0]         cfg_wdata,
    input  logic                frame_start,
    input  logic                in_valid,
    input  logic                in_csc_en,
    input  logic [3*DATA_W-1:0] in_pix,
    output logic                out_valid,
    output logic [3*DATA_W-1:0] out_pix,
    output logic                out_pre_gamma
);
    cfg_t active;

    csc_regs u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .we          (cfg_we),
        .addr        (cfg_addr),
        .wdata       (cfg_wdata),
        .frame_start (frame_start),
        .active      (active)
    );

    csc_datapath #(.DATA_W(DATA_W)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg       (active),
        .in_valid  (in_valid),
        .in_csc_en (in_csc_en),
        .in_pix    (in_pix),
        .out_valid (out_valid),
        .out_pix   (out_pix)
    );

    assign out_pre_gamma = active.before_gamma;
endmodule

// File: tb/csc_matrix_bench.sv
`timescale 1ns/1ps
module csc_matrix_bench;
    localparam int DW = 8;
    localparam int PW = 3 * DW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [7:0]    cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0;
    logic          frame_start = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_csc_en = 1'b0;
    logic [PW-1:0] in_pix = '0;
    logic          out_valid;
    logic [PW-1:0] out_pix;
    logic          out_pre_gamma;

    csc_matrix #(.DATA_W(DW)) u_csc_matrix (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .frame_start(frame_start), .in_valid(in_valid),
        .in_csc_en(in_csc_en), .in_pix(in_pix), .out_valid(out_valid),
        .out_pix(out_pix), .out_pre_gamma(out_pre_gamma)
    );

    always #2.5 clk = ~clk;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    // behavioural settings model
    int sh_coef [3][3];
    int ac_coef [3][3];
    int sh_pre [3], ac_pre [3], sh_post [3], ac_post [3];
    bit sh_bg, ac_bg, sh_blk, ac_blk;
    bit            ev [3];
    logic [PW-1:0] ep [3];

    task automatic chk(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    function automatic real gain_of(input int c);
        int  e, m;
        real g;
        e = (c >> 12) & 7;
        m = (c >> 3) & 511;
        if (e == 0) g = m / 512.0;
        else        g = m * (2.0 ** (e - 6)) / 512.0;
        if (c & 32'h8000) g = -g;
        return g;
    endfunction

    function automatic logic [PW-1:0] model_pix(input logic [PW-1:0] p);
        logic [PW-1:0] r;
        real acc, xin, f;
        int  v, pv;
        for (int k = 0; k < 3; k++) begin
            pv  = ac_blk ? 514 : ac_post[k];
            acc = pv * 255.0 / 8192.0;
            for (int j = 0; j < 3; j++) begin
                xin = real'(int'(p[j*DW +: DW])) - ac_pre[j] * 255.0 / 8192.0;
                acc = acc + gain_of(ac_coef[k][j]) * xin;
            end
            f = $floor(acc + 0.5);
            if (f < 0.0)        v = 0;
            else if (f > 255.0) v = 255;
            else                v = int'(f);
            r[k*DW +: DW] = DW'(v);
        end
        return r;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [31:0] d);
        for (int r = 0; r < 3; r++) begin
            if (a == 8'(16 + 8 * r)) begin sh_coef[r][0] = int'(d[31:16]); sh_coef[r][1] = int'(d[15:0]); end
            if (a == 8'(20 + 8 * r)) sh_coef[r][2] = int'(d[31:16]);
            if (a == 8'(48 + 4 * r)) sh_pre[r]  = int'(d[12:0]);
            if (a == 8'(64 + 4 * r)) sh_post[r] = int'(d[12:0]);
        end
        if (a == 8'h28) begin sh_bg = d[1]; sh_blk = d[2]; end
    endtask

    task automatic cyc(input bit we, input logic [7:0] a, input logic [31:0] d,
                       input bit fs, input bit v, input bit en, input logic [PW-1:0] p);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; frame_start = fs;
        in_valid = v; in_csc_en = en; in_pix = p;
        @(posedge clk);
        ev[2] = ev[1]; ep[2] = ep[1];
        ev[1] = ev[0]; ep[1] = ep[0];
        ev[0] = v;
        ep[0] = en ? model_pix(p) : p;
        if (fs) begin
            ac_coef = sh_coef; ac_pre = sh_pre; ac_post = sh_post;
            ac_bg = sh_bg; ac_blk = sh_blk;
        end
        if (we) model_write(a, d);
        @(negedge clk);
        chk(out_valid === ev[2], cur_req, longint'(out_valid), longint'(ev[2]));
        if (ev[2]) chk(out_pix === ep[2], cur_req, longint'(out_pix), longint'(ep[2]));
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b0, 1'b0, 1'b0, '0);
    endtask
    task automatic fs_pulse();
        cyc(1'b0, '0, '0, 1'b1, 1'b0, 1'b0, '0);
    endtask
    task automatic px(input bit en, input logic [PW-1:0] p);
        cyc(1'b0, '0, '0, 1'b0, 1'b1, en, p);
    endtask
    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, '0);
    endtask
    task automatic diag(input logic [15:0] c);
        wr(8'h10, {c, 16'h0}); wr(8'h14, 32'h0);
        wr(8'h18, {16'h0, c}); wr(8'h1C, 32'h0);
        wr(8'h20, 32'h0);      wr(8'h24, {c, 16'h0});
    endtask
    task automatic offsets(input int pre, input int post);
        for (int i = 0; i < 3; i++) begin
            wr(8'(48 + 4 * i), 32'(pre));
            wr(8'(64 + 4 * i), 32'(post));
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        #(150000 * 5);
        checks++; errors++;
        $display("FAIL watchdog: actual running expected done");
        summary();
        $finish;
    end

    initial begin
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 3; j++) sh_coef[k][j] = (k == j) ? 32'h7800 : 0;
            sh_pre[k] = 0; sh_post[k] = 0; ev[k] = 1'b0; ep[k] = '0;
        end
        sh_bg = 0; sh_blk = 0;
        ac_coef = sh_coef; ac_pre = sh_pre; ac_post = sh_post; ac_bg = 0; ac_blk = 0;

        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        chk(out_valid === 1'b0, "R1", longint'(out_valid), 0);
        chk(out_pre_gamma === 1'b0, "R1", longint'(out_pre_gamma), 0);
        rst_n = 1'b1;
        @(negedge clk);
        px(1, 24'h123456); px(1, 24'hFF00FF); px(1, 24'h000000); px(1, 24'hFFFFFF);
        for (int i = 0; i < 20; i++) px(1, PW'($urandom));
        idle(3);

        // R2: valid pattern with gaps
        cur_req = "R2";
        for (int i = 0; i < 30; i++) cyc(0, '0, '0, 0, (i % 3) != 1, 1, PW'($urandom));
        idle(3);

        // R9: shadow writes do not act before frame start
        cur_req = "R9";
        diag(16'h0DB8); offsets(0, 514);
        px(1, 24'hFFFFFF); px(1, 24'h000000); px(1, 24'h808080);
        idle(3);
        // write coinciding with the strobe stays in the shadow only
        cyc(1, 8'h30, 32'd2000, 1, 0, 0, '0);
        cur_req = "R6";
        px(1, 24'h000000); px(1, 24'hFFFFFF); px(1, 24'h10EB80);
        idle(3);
        cur_req = "R9";
        fs_pulse();
        px(1, 24'hFFFFFF); px(1, 24'h404040);
        idle(3);

        // R7: black offset replaces programmed output offsets
        cur_req = "R7";
        offsets(0, 0);
        wr(8'h40, 32'd4000);
        wr(8'h28, 32'h4);
        fs_pulse();
        px(1, 24'h000000); px(1, 24'hFFFFFF); px(1, 24'h7F7F7F);
        idle(3);

        // R11: before-gamma flag follows the working copy
        cur_req = "R11";
        wr(8'h28, 32'h2);
        chk(out_pre_gamma === 1'b0, "R11", longint'(out_pre_gamma), 0);
        fs_pulse();
        chk(out_pre_gamma === 1'b1, "R11", longint'(out_pre_gamma), 1);

        // R8: saturation high and low, rounding ties
        cur_req = "R8";
        diag(16'h7FF8); offsets(0, 0); wr(8'h28, 32'h0);
        fs_pulse();
        px(1, 24'hC8C8C8); px(1, 24'h010203);
        idle(3);
        diag(16'hF800);
        fs_pulse();
        px(1, 24'h0A0B0C); px(1, 24'h000000);
        idle(3);
        diag(16'h0800);
        fs_pulse();
        px(1, 24'h010203); px(1, 24'hFFFEFD); px(1, 24'h050607);
        idle(3);

        // R4: exponent codes and ignored low bits
        cur_req = "R4";
        diag(16'h5807);
        fs_pulse();
        px(1, 24'h8040FF); px(1, 24'h0C1020);
        idle(3);
        diag(16'h3A47);
        fs_pulse();
        for (int i = 0; i < 10; i++) px(1, PW'($urandom));
        idle(3);

        // R10: bypass with a non-identity setup, interleaved with conversion
        cur_req = "R10";
        for (int i = 0; i < 30; i++) px(i % 2 == 0, PW'($urandom));
        idle(3);

        // R5: unmapped offsets change nothing
        cur_req = "R5";
        wr(8'h2C, 32'hFFFFFFFF); wr(8'h4C, 32'hFFFFFFFF); wr(8'h0C, 32'hFFFFFFFF);
        fs_pulse();
        for (int i = 0; i < 10; i++) px(1, PW'($urandom));
        idle(3);

        // R3 / R5: random full matrices and offsets
        cur_req = "R3";
        for (int c = 0; c < 8; c++) begin
            for (int r = 0; r < 6; r++) wr(8'(16 + 4 * r), $urandom);
            for (int i = 0; i < 3; i++) begin
                wr(8'(48 + 4 * i), $urandom & 32'h3FF);
                wr(8'(64 + 4 * i), $urandom & 32'h1FFF);
            end
            wr(8'h28, $urandom & 32'h6);
            fs_pulse();
            for (int i = 0; i < 150; i++)
                cyc(0, '0, '0, 0, ($urandom % 5) != 0, ($urandom % 10) != 0, PW'($urandom));
            idle(3);
        end

        summary();
        $finish;
    end
endmodule